// File: doc/BRIEF.md
# Indirect-Access Network Controller Register Block

This block is the processor-facing register front end of a small network controller. Software reaches four 16-bit control registers through two 16-bit ports. The pointer port chooses a register index. The data port then reads or writes the register at that index. Register 0 is the main status word. It holds the stop state, the interrupt enable and the transmit and receive completion flags. Registers 1 and 2 together form a 32-bit descriptor-area pointer. Register 3 is plain storage.

A second window holds four 32-bit helper registers for the DMA path. The last of these is an offset that the block adds to the descriptor pointer to give the effective descriptor base. The block watches completion pulses from the receive and transmit engines and folds them into the status flags. It drives a single interrupt line. It also sends a one-cycle poll strobe to the transmit engine after every write to the register ports. The block does not process descriptors and does not access memory.

Top module: `nic_ctrl_regs`

## Requirements
- R1: Register-port offset is `reg_addr[2:1]` and `reg_addr[0]` is ignored. Offset 0 is the data port and offset 1 is the pointer port. Offsets 2 and 3 read as 0x0000, and writes to them change no state.
- R2: A read of the data port returns the register the pointer selects. A read of the pointer port returns the pointer value, zero-extended to 16 bits. Both reads are combinational.
- R3: A pointer-port write stores the written value only if it is below 4. Otherwise the pointer keeps its previous value.
- R4: After reset the pointer is 0 and registers 1 to 3 are 0x0000. The status word reads 0x0004 (stop only), all four DMA registers are zero and `irq` is low.
- R5: A data-port write with pointer 1 replaces bits [15:0] of the descriptor pointer. A write with pointer 2 replaces bits [31:16]. Neither write changes the other half. `desc_base` equals the descriptor pointer plus DMA register 3.
- R6: The DMA window holds four 32-bit registers indexed by `dma_addr[3:2]`, with `dma_addr[1:0]` ignored. A write stores the word on the clock edge, and a read returns the stored word combinationally.
- R7: Status bit 7 (summary) is the OR of bits 9 and 10. `irq` is high exactly when the summary bit and bit 6 (interrupt enable) are both set.
- R8: While not stopped, a `rx_done` pulse sets bit 10 and a `tx_done` pulse sets bit 9. While stopped, both pulses are ignored. If an event arrives in the same cycle as a write-one-to-clear of its flag, the event wins.
- R9: Writing the status word works as follows. Bit 2 (stop) takes the written value. A 1 there also clears bits 6, 9 and 10. Otherwise bit 6 takes the written value, and a 1 in bit 9 or bit 10 clears that flag. Bit 3 (transmit demand) and all other unlisted bits read as 0.
- R10: `tx_poll` is high for exactly the one cycle after each accepted write to offset 0 or 1, including a dropped pointer write. A write to offset 2 or 3 gives no poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register-port access strobe |
| reg_wr | input | 1 | Write qualifier for the register port |
| reg_addr | input | 3 | Register-port byte address |
| reg_wdata | input | 16 | Register-port write data |
| reg_rdata | output | 16 | Register-port read data |
| dma_sel | input | 1 | DMA-window access strobe |
| dma_wr | input | 1 | Write qualifier for the DMA window |
| dma_addr | input | 4 | DMA-window byte address |
| dma_wdata | input | 32 | DMA-window write data |
| dma_rdata | output | 32 | DMA-window read data |
| rx_done | input | 1 | Receive-completion event pulse |
| tx_done | input | 1 | Transmit-completion event pulse |
| irq | output | 1 | Interrupt request |
| tx_poll | output | 1 | Transmit poll strobe |
| desc_base | output | 32 | Effective descriptor base address |

## Verification
The assertions assume that `rst_n` is low at time zero and that every control input is at a known level at each clock edge. They also assume that event pulses and bus writes are single-cycle requests sampled on the edge. No handshake or back-pressure is expected. The stimulus changes every input only on the falling edge. Each write is held for exactly one rising edge. Events are raised alone or together with a status write, always while the pointer is known to select the status word, so every check has one well-defined expected result.

// File: rtl/nicreg_pkg.sv
package nicreg_pkg;

    // Default geometry of the register port and DMA window
    localparam int unsigned DEF_REG_W     = 16;
    localparam int unsigned DEF_NUM_REGS  = 4;
    localparam int unsigned DEF_DMA_W     = 32;
    localparam int unsigned DEF_DMA_NUM   = 4;
    localparam int unsigned DEF_RADDR_W   = 3;
    localparam int unsigned DEF_DADDR_W   = 4;

    // Status word bit positions (software-visible encoding)
    localparam int unsigned ST_STOP = 2;
    localparam int unsigned ST_TDMD = 3;
    localparam int unsigned ST_INEA = 6;
    localparam int unsigned ST_INTR = 7;
    localparam int unsigned ST_TINT = 9;
    localparam int unsigned ST_RINT = 10;

    // Register-port offsets, taken from byte-address bits [2:1]
    typedef enum logic [1:0] {
        PORT_DATA = 2'd0,
        PORT_PTR  = 2'd1,
        PORT_RSV2 = 2'd2,
        PORT_RSV3 = 2'd3
    } port_e;

    // Stored state of the status word
    typedef struct packed {
        logic stop;
        logic inea;
        logic tint;
        logic rint;
    } status_t;

endpackage

// File: rtl/nic_port_decode.sv
module nic_port_decode
    import nicreg_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_RADDR_W
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output port_e             port,
    output logic              data_wr,
    output logic              ptr_wr,
    output logic              port_wr
);

    logic unused_addr_lsb;

    always_comb begin
        port    = port_e'(addr[2:1]);
        data_wr = sel && wr && (port == PORT_DATA);
        ptr_wr  = sel && wr && (port == PORT_PTR);
        port_wr = data_wr || ptr_wr;
    end

    assign unused_addr_lsb = addr[0];

endmodule

// File: rtl/nic_status_csr.sv
module nic_status_csr
    import nicreg_pkg::*;
#(
    parameter int unsigned REG_W = DEF_REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             rx_evt,
    input  logic             tx_evt,
    output logic [REG_W-1:0] status,
    output logic             irq
);

    status_t st_d, st_q;
    logic    summary;
    logic    stop_wr;
    logic    unused_wbits;

    always_comb begin
        st_d    = st_q;
        stop_wr = wr_en && wdata[ST_STOP];
        if (wr_en) begin
            if (wdata[ST_STOP]) begin
                st_d.stop = 1'b1;
                st_d.inea = 1'b0;
                st_d.tint = 1'b0;
                st_d.rint = 1'b0;
            end else begin
                st_d.stop = 1'b0;
                st_d.inea = wdata[ST_INEA];
                if (wdata[ST_TINT]) st_d.tint = 1'b0;
                if (wdata[ST_RINT]) st_d.rint = 1'b0;
            end
        end
        // Events land after the clear so a simultaneous event survives
        if (!st_q.stop && !stop_wr) begin
            if (rx_evt) st_d.rint = 1'b1;
            if (tx_evt) st_d.tint = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{stop: 1'b1, inea: 1'b0, tint: 1'b0, rint: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        summary          = st_q.tint || st_q.rint;
        status           = '0;
        status[ST_STOP]  = st_q.stop;
        status[ST_INEA]  = st_q.inea;
        status[ST_INTR]  = summary;
        status[ST_TINT]  = st_q.tint;
        status[ST_RINT]  = st_q.rint;
        irq              = summary && st_q.inea;
    end

    assign unused_wbits = ^wdata;

    // R8: a receive event while running is visible next cycle
    p_rx_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt && !status[ST_STOP] && !stop_wr) |=> status[ST_RINT]);

    // R8: events are ignored while stopped and not restarted
    p_stop_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_STOP] && !wr_en) |=> $stable(status));

    // R7: the interrupt can only rise after an event or a write
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(rx_evt || tx_evt || wr_en));

    // R9: a stopped controller never requests an interrupt
    p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_STOP] |-> !irq);

endmodule

// File: rtl/nic_dma_window.sv
module nic_dma_window
    import nicreg_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DMA_W,
    parameter int unsigned NUM    = DEF_DMA_NUM,
    parameter int unsigned ADDR_W = DEF_DADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] base_off
);

    localparam int unsigned IDX_W = $clog2(NUM);

    logic [NUM-1:0][DATA_W-1:0] regs_d, regs_q;
    logic [NUM-1:0]             wen;
    logic [IDX_W-1:0]           idx;
    logic                       unused_byte_bits;

    assign idx              = addr[IDX_W+1:2];
    assign unused_byte_bits = ^addr[1:0];

    for (genvar g = 0; g < NUM; g++) begin : g_wen
        assign wen[g] = sel && wr && (idx == IDX_W'(g));
    end

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM; i++) begin
            if (wen[i]) regs_d[i] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata    = regs_q[idx];
    assign base_off = regs_q[NUM-1];

    // R6: a written word is read back from the same index
    p_dma_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr) |=> (regs_q[$past(idx)] == $past(wdata)));

    // R6: at most one register is written per cycle
    p_dma_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wen));

endmodule

// File: rtl/nic_ctrl_regs.sv
module nic_ctrl_regs
    import nicreg_pkg::*;
#(
    parameter int unsigned REG_W    = DEF_REG_W,
    parameter int unsigned NUM_REGS = DEF_NUM_REGS,
    parameter int unsigned DMA_W    = DEF_DMA_W,
    parameter int unsigned DMA_NUM  = DEF_DMA_NUM,
    parameter int unsigned RADDR_W  = DEF_RADDR_W,
    parameter int unsigned DADDR_W  = DEF_DADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               dma_sel,
    input  logic               dma_wr,
    input  logic [DADDR_W-1:0] dma_addr,
    input  logic [DMA_W-1:0]   dma_wdata,
    output logic [DMA_W-1:0]   dma_rdata,
    input  logic               rx_done,
    input  logic               tx_done,
    output logic               irq,
    output logic               tx_poll,
    output logic [DMA_W-1:0]   desc_base
);

    localparam int unsigned PTR_W   = $clog2(NUM_REGS);
    localparam int unsigned IDX_LO  = 1;
    localparam int unsigned IDX_HI  = 2;

    typedef struct packed {
        logic [PTR_W-1:0]                 ptr;
        logic [NUM_REGS-1:1][REG_W-1:0]   aux;
        logic                             poll;
    } top_state_t;

    top_state_t        s_d, s_q;
    port_e             port;
    logic              data_wr, ptr_wr, port_wr;
    logic              status_wr;
    logic [REG_W-1:0]  status_word;
    logic [DMA_W-1:0]  base_off;
    logic [DMA_W-1:0]  desc_ptr;

    nic_port_decode #(.ADDR_W(RADDR_W)) u_decode (
        .sel     (reg_sel),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .port    (port),
        .data_wr (data_wr),
        .ptr_wr  (ptr_wr),
        .port_wr (port_wr)
    );

    assign status_wr = data_wr && (s_q.ptr == '0);

    nic_status_csr #(.REG_W(REG_W)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (status_wr),
        .wdata  (reg_wdata),
        .rx_evt (rx_done),
        .tx_evt (tx_done),
        .status (status_word),
        .irq    (irq)
    );

    nic_dma_window #(
        .DATA_W (DMA_W),
        .NUM    (DMA_NUM),
        .ADDR_W (DADDR_W)
    ) u_dma (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (dma_sel),
        .wr       (dma_wr),
        .addr     (dma_addr),
        .wdata    (dma_wdata),
        .rdata    (dma_rdata),
        .base_off (base_off)
    );

    always_comb begin
        s_d      = s_q;
        s_d.poll = port_wr;
        if (ptr_wr && (reg_wdata < REG_W'(NUM_REGS))) begin
            s_d.ptr = reg_wdata[PTR_W-1:0];
        end
        if (data_wr && (s_q.ptr != '0)) begin
            s_d.aux[s_q.ptr] = reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (port)
            PORT_DATA: reg_rdata = (s_q.ptr == '0) ? status_word : s_q.aux[s_q.ptr];
            PORT_PTR:  reg_rdata = REG_W'(s_q.ptr);
            default:   reg_rdata = '0;
        endcase
    end

    assign desc_ptr  = DMA_W'({s_q.aux[IDX_HI], s_q.aux[IDX_LO]});
    assign desc_base = desc_ptr + base_off;
    assign tx_poll   = s_q.poll;

    // R3: an out-of-range pointer write leaves the pointer unchanged
    p_ptr_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wr && (reg_wdata >= REG_W'(NUM_REGS))) |=> $stable(s_q.ptr));

    // R10: every accepted port write produces a poll next cycle
    p_poll_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |=> tx_poll);

    // R10: no poll without a preceding port write
    p_poll_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_poll |-> $past(port_wr));

    // R5: writing the low half keeps the high half
    p_desc_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && (s_q.ptr == PTR_W'(IDX_LO))) |=>
            (s_q.aux[IDX_LO] == $past(reg_wdata)) && $stable(s_q.aux[IDX_HI]));

    // R1: reserved offsets never change stored state
    p_rsv_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_addr[2] && !rx_done && !tx_done) |=>
            $stable(s_q.ptr) && $stable(s_q.aux) && $stable(status_word));

endmodule

// File: tb/tb_nic_ctrl_regs.sv
module tb_nic_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        dma_sel = 1'b0;
    logic        dma_wr = 1'b0;
    logic [3:0]  dma_addr = '0;
    logic [31:0] dma_wdata = '0;
    logic [31:0] dma_rdata;
    logic        rx_done = 1'b0;
    logic        tx_done = 1'b0;
    logic        irq;
    logic        tx_poll;
    logic [31:0] desc_base;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    nic_ctrl_regs dut (
        .clk(clk), .rst_n(rst_n),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dma_sel(dma_sel), .dma_wr(dma_wr), .dma_addr(dma_addr),
        .dma_wdata(dma_wdata), .dma_rdata(dma_rdata),
        .rx_done(rx_done), .tx_done(tx_done),
        .irq(irq), .tx_poll(tx_poll), .desc_base(desc_base)
    );

    typedef struct packed {
        logic        is_wr;
        logic [2:0]  addr;
        logic [15:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 16'h0004, 8'd4},   // R4 status after reset
        '{1'b0, 3'd2, 16'h0000, 8'd4},   // R4 pointer after reset
        '{1'b1, 3'd2, 16'h0001, 8'd2},
        '{1'b1, 3'd0, 16'h1234, 8'd5},
        '{1'b0, 3'd0, 16'h1234, 8'd2},   // R2 data read of reg 1
        '{1'b0, 3'd2, 16'h0001, 8'd2},   // R2 pointer read
        '{1'b1, 3'd2, 16'h0002, 8'd2},
        '{1'b1, 3'd0, 16'hABCD, 8'd5},
        '{1'b0, 3'd0, 16'hABCD, 8'd5},   // R5 high half
        '{1'b1, 3'd2, 16'h0007, 8'd3},
        '{1'b0, 3'd2, 16'h0002, 8'd3},   // R3 dropped pointer write
        '{1'b1, 3'd2, 16'h0004, 8'd3},
        '{1'b0, 3'd2, 16'h0002, 8'd3},   // R3 boundary value 4
        '{1'b1, 3'd2, 16'h0003, 8'd3},
        '{1'b0, 3'd3, 16'h0003, 8'd3},   // R3 value 3 accepted, R1 lsb ignored
        '{1'b1, 3'd0, 16'h5A5A, 8'd2},
        '{1'b0, 3'd1, 16'h5A5A, 8'd1},   // R1 odd byte maps to data port
        '{1'b1, 3'd2, 16'h0001, 8'd5},
        '{1'b0, 3'd0, 16'h1234, 8'd5},   // R5 low half kept
        '{1'b1, 3'd4, 16'hFFFF, 8'd1},
        '{1'b0, 3'd4, 16'h0000, 8'd1},   // R1 reserved offset reads zero
        '{1'b0, 3'd2, 16'h0001, 8'd1},   // R1 reserved write did nothing
        '{1'b1, 3'd2, 16'h0000, 8'd9},
        '{1'b1, 3'd0, 16'h0040, 8'd9},
        '{1'b1, 3'd0, 16'h0648, 8'd9},
        '{1'b0, 3'd0, 16'h0040, 8'd9}    // R9 start, enable, tdmd reads 0
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic dma_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        dma_sel = 1'b1; dma_wr = 1'b1; dma_addr = a; dma_wdata = d;
        @(negedge clk);
        dma_sel = 1'b0; dma_wr = 1'b0;
    endtask

    task automatic pulse_evt(input logic rx, input logic tx);
        @(negedge clk);
        rx_done = rx; tx_done = tx;
        @(negedge clk);
        rx_done = 1'b0; tx_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 reset-state outputs
        check("R4 irq", {31'd0, irq}, 32'd0);
        check("R4 desc_base", desc_base, 32'd0);
        dma_addr = 4'hC; #1;
        check("R4 dma reg3", dma_rdata, 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_wr) begin
                bus_write(VECS[i].addr, VECS[i].data);
            end else begin
                bus_read(VECS[i].addr, rd);
                check($sformatf("R%0d vec%0d", VECS[i].req, i), {16'd0, rd}, {16'd0, VECS[i].data});
            end
        end

        // R6 DMA window write and read back
        dma_write(4'h0, 32'h1111_1111);
        dma_write(4'h4, 32'h2222_2222);
        dma_write(4'h8, 32'h3333_3333);
        dma_write(4'hC, 32'h0000_0010);
        for (int k = 0; k < 4; k++) begin
            dma_addr = 4'(k * 4); #1;
            check("R6 dma readback", dma_rdata,
                  (k == 3) ? 32'h0000_0010 : {8{4'(k + 1)}});
        end
        dma_addr = 4'hF; #1;
        check("R6 byte bits ignored", dma_rdata, 32'h0000_0010);

        // R5 effective base = pointer + DMA reg 3
        check("R5 desc_base", desc_base, 32'hABCD_1244);

        // R7 R8 receive event raises flag and interrupt
        pulse_evt(1'b1, 1'b0);
        bus_read(3'd0, rd);
        check("R8 rx sets flag", {16'd0, rd}, 32'h0000_04C0);
        check("R7 irq high", {31'd0, irq}, 32'd1);

        // R9 write-one-to-clear of receive flag
        bus_write(3'd0, 16'h0440);
        bus_read(3'd0, rd);
        check("R9 w1c rint", {16'd0, rd}, 32'h0000_0040);
        check("R7 irq low", {31'd0, irq}, 32'd0);

        // R8 transmit event
        pulse_evt(1'b0, 1'b1);
        bus_read(3'd0, rd);
        check("R8 tx sets flag", {16'd0, rd}, 32'h0000_02C0);

        // R8 event beats simultaneous clear
        @(negedge clk);
        tx_done = 1'b1; reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'h0240;
        @(negedge clk);
        tx_done = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0;
        bus_read(3'd0, rd);
        check("R8 event wins over clear", {16'd0, rd}, 32'h0000_02C0);

        // R7 flag set without enable gives no interrupt
        bus_write(3'd0, 16'h0200);
        pulse_evt(1'b1, 1'b0);
        bus_read(3'd0, rd);
        check("R7 flag without enable", {16'd0, rd}, 32'h0000_0480);
        check("R7 irq needs enable", {31'd0, irq}, 32'd0);

        // R9 stop write clears enable and flags
        bus_write(3'd0, 16'h0644);
        bus_read(3'd0, rd);
        check("R9 stop clears", {16'd0, rd}, 32'h0000_0004);

        // R8 events ignored while stopped
        pulse_evt(1'b1, 1'b1);
        bus_read(3'd0, rd);
        check("R8 stopped ignores events", {16'd0, rd}, 32'h0000_0004);

        // R10 poll strobe behaviour
        bus_write(3'd2, 16'h0009);
        check("R10 poll after dropped ptr write", {31'd0, tx_poll}, 32'd1);
        @(negedge clk);
        check("R10 poll one cycle", {31'd0, tx_poll}, 32'd0);
        bus_write(3'd6, 16'h0001);
        check("R10 no poll on reserved offset", {31'd0, tx_poll}, 32'd0);
        bus_write(3'd0, 16'h0004);
        check("R10 poll after data write", {31'd0, tx_poll}, 32'd1);

        // R4 reset in mid-run
        bus_write(3'd2, 16'h0003);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        bus_read(3'd2, rd);
        check("R4 pointer cleared", {16'd0, rd}, 32'd0);
        bus_read(3'd0, rd);
        check("R4 status stop only", {16'd0, rd}, 32'h0000_0004);
        dma_addr = 4'hC; #1;
        check("R4 dma cleared", dma_rdata, 32'd0);
        check("R4 base cleared", desc_base, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule